// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps time of day and the calendar date, advancing by one second on each pulse of a 1 Hz tick. Inside it counts in plain binary (seconds, minutes, hours 0 to 23, weekday 1 to 7, day of month, month, two-digit year). The visible time registers are produced from that counter in the format the mode byte selects: packed BCD or binary, and 24-hour or 12-hour with a PM marker. The full Gregorian leap rule applies. The century used for the leap rule is a parameter.

Each accepted tick starts a two-phase update, driven by a three-state machine:

| State | Role | Transition out |
|---|---|---|
| IDLE | Waits for a tick. | Goes to BUSY on a tick when the oscillator field reads run and no load is present. The counter steps at that edge, and the update-in-progress flag rises unless hold is set. |
| BUSY | Counts `UIP_CYCLES` clock cycles. | Goes to DONE when the window count reaches its end. |
| DONE | Lasts one cycle. The visible registers refresh unless hold is set. The alarm and update-ended results go out as a one-cycle flag byte, and the busy flag drops. | Always returns to IDLE. |

A load strobe writes new time values. They are decoded from the current format into the counter, and they are copied into the visible registers as written.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the visible registers read sec 0x00, min 0x00, hr 0x00, weekday 0x01, day 0x01, month 0x01 and year 0x00, and uip_o and flags_o are 0.
- R2: A tick advances the time only when osc_i equals 3'b010. For any other value the tick is ignored: the time does not move and uip_o stays low.
- R3: Seconds and minutes wrap from 59 to 0 with a carry. Hours wrap from 23 to 0. The weekday counts 1 to 7 and returns to 1 when the day rolls over.
- R4: The month lengths are 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30 and 31 days. February has 29 days when the full year (CENTURY*100 + year) is divisible by 4 and is either not divisible by 100 or divisible by 400. After the last day, the day goes to 1 and the month advances, and December goes to January.
- R5: The year runs 0 to 99 and wraps from 99 to 0 when December rolls over.
- R6: When mode_i bit 2 is 0, every time register is packed BCD, with tens in bits 7:4 and units in bits 3:0. When mode_i bit 2 is 1, the registers are plain binary.
- R7: When mode_i bit 1 is 0 (12-hour mode), the hours register holds hour modulo 12 in bits 6:0, and bit 7 is 1 for hours 12 to 23. On load in this mode, bit 7 adds 12 to the hour.
- R8: Each alarm byte matches when its bits 7:6 are both 1, or when it equals the current register-format value of its field. When mode_i bit 5 is 1 and seconds, minutes and hours all match, the update pulse carries flags_o bits 7 and 5.
- R9: When mode_i bit 4 is 1 and bit 7 is 0, every completed update pulses flags_o bits 7 and 4.
- R10: uip_o rises on the cycle after an accepted tick and stays high for UIP_CYCLES+1 cycles. It falls at the same edge where the registers refresh and flags_o is non-zero for exactly one cycle.
- R11: While mode_i bit 7 (hold) is 1, the visible registers are not refreshed, uip_o stays low and no update-ended flag is raised, but the counter keeps running.
- R12: A one-cycle ld_i copies the ld_* bytes into the visible registers on the next cycle and loads the counter with their decoded value. A load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 1 Hz pulse |
| mode_i | input | 8 | Bit 7 hold, bit 5 alarm enable, bit 4 update-ended enable, bit 2 binary, bit 1 24-hour |
| osc_i | input | 3 | Oscillator control; 3'b010 runs |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hr_i | input | 8 | Alarm hours byte |
| ld_i | input | 1 | Load strobe |
| ld_sec_i | input | 8 | Seconds to load |
| ld_min_i | input | 8 | Minutes to load |
| ld_hr_i | input | 8 | Hours to load |
| ld_wday_i | input | 8 | Weekday to load |
| ld_mday_i | input | 8 | Day of month to load |
| ld_mon_i | input | 8 | Month to load |
| ld_year_i | input | 8 | Year to load |
| sec_o | output | 8 | Seconds register |
| min_o | output | 8 | Minutes register |
| hr_o | output | 8 | Hours register |
| wday_o | output | 8 | Weekday register |
| mday_o | output | 8 | Day-of-month register |
| mon_o | output | 8 | Month register |
| year_o | output | 8 | Year register |
| uip_o | output | 1 | Update in progress |
| flags_o | output | 8 | One-cycle flag byte: bit 7 any, bit 5 alarm, bit 4 update ended |

## Verification
The stepping function is exercised from chosen start values, and each start value separates one carry path from the others:
- a plain seconds-to-minutes carry;
- a full year-end rollover;
- the last day of 30-day and 31-day months;
- February 28 and 29 in years 00, 01 and 04.

The same steps are repeated in binary and in 12-hour mode. A units digit of 9 tells BCD from binary output. The noon, 1 PM and 11 PM crossings tell the PM bit from the hour modulo 12.

The alarm is driven with exact, mismatching and don't-care bytes, with and without its enable, to show which conditions gate each flag bit. Hold and the oscillator field are toggled to show a tick being frozen or dropped, and then to show the counter catching up once hold is released.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Mode byte bit positions
    localparam int MB_HOLD    = 7;
    localparam int MB_ALM_EN  = 5;
    localparam int MB_UEND_EN = 4;
    localparam int MB_BIN     = 2;
    localparam int MB_H24     = 1;

    // Flag byte bit positions
    localparam int FB_ANY  = 7;
    localparam int FB_ALM  = 5;
    localparam int FB_UEND = 4;

    localparam logic [2:0] OSC_RUN = 3'b010;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hr;
        logic [6:0] wday;
        logic [6:0] mday;
        logic [6:0] mon;
        logic [6:0] year;
    } tod_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } regs_t;

    typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} upd_state_e;

    localparam tod_t  TOD_RESET  = '{7'd0, 7'd0, 7'd0, 7'd1, 7'd1, 7'd1, 7'd0};
    localparam regs_t REGS_RESET = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

    // Binary count to register byte
    function automatic logic [7:0] to_reg(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], units[3:0]};
    endfunction

    // Register byte to binary count
    function automatic logic [6:0] from_reg(input logic [7:0] r, input logic bin);
        logic [7:0] sum;
        sum = ({4'b0, r[7:4]} * 8'd10) + {4'b0, r[3:0]};
        return bin ? r[6:0] : sum[6:0];
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic leap);
        case (mon)
            7'd2:                        return leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
            default:                     return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
#(
    parameter int CENTURY = 20
) (
    input  tod_t cur_i,
    output tod_t nxt_o
);
    localparam logic CENT_LEAP = ((CENTURY % 4) == 0);

    logic       leap;
    logic [6:0] dim;

    always_comb begin
        leap  = (cur_i.year[1:0] == 2'b00) && ((cur_i.year != 7'd0) || CENT_LEAP);
        dim   = month_days(cur_i.mon, leap);
        nxt_o = cur_i;
        if (cur_i.sec < 7'd59) begin
            nxt_o.sec = cur_i.sec + 7'd1;
        end else begin
            nxt_o.sec = 7'd0;
            if (cur_i.min < 7'd59) begin
                nxt_o.min = cur_i.min + 7'd1;
            end else begin
                nxt_o.min = 7'd0;
                if (cur_i.hr < 7'd23) begin
                    nxt_o.hr = cur_i.hr + 7'd1;
                end else begin
                    nxt_o.hr   = 7'd0;
                    nxt_o.wday = (cur_i.wday >= 7'd7) ? 7'd1 : cur_i.wday + 7'd1;
                    if (cur_i.mday < dim) begin
                        nxt_o.mday = cur_i.mday + 7'd1;
                    end else begin
                        nxt_o.mday = 7'd1;
                        if (cur_i.mon < 7'd12) begin
                            nxt_o.mon = cur_i.mon + 7'd1;
                        end else begin
                            nxt_o.mon  = 7'd1;
                            nxt_o.year = (cur_i.year >= 7'd99) ? 7'd0 : cur_i.year + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_cal_encode.sv
module rtc_cal_encode
    import rtc_cal_pkg::*;
(
    input  tod_t  tod_i,
    input  logic  bin_i,
    input  logic  h24_i,
    output regs_t regs_o
);
    logic       pm;
    logic [6:0] hr12;
    logic [7:0] hr12_byte;

    always_comb begin
        pm        = (tod_i.hr >= 7'd12);
        hr12      = pm ? (tod_i.hr - 7'd12) : tod_i.hr;
        hr12_byte = to_reg(hr12, bin_i);
        regs_o.sec  = to_reg(tod_i.sec, bin_i);
        regs_o.min  = to_reg(tod_i.min, bin_i);
        regs_o.hr   = h24_i ? to_reg(tod_i.hr, bin_i) : {pm, hr12_byte[6:0]};
        regs_o.wday = to_reg(tod_i.wday, bin_i);
        regs_o.mday = to_reg(tod_i.mday, bin_i);
        regs_o.mon  = to_reg(tod_i.mon, bin_i);
        regs_o.year = to_reg(tod_i.year, bin_i);
    end
endmodule

// File: rtl/rtc_cal_decode.sv
module rtc_cal_decode
    import rtc_cal_pkg::*;
(
    input  regs_t regs_i,
    input  logic  bin_i,
    input  logic  h24_i,
    output tod_t  tod_o
);
    always_comb begin
        tod_o.sec  = from_reg(regs_i.sec, bin_i);
        tod_o.min  = from_reg(regs_i.min, bin_i);
        tod_o.hr   = h24_i ? from_reg(regs_i.hr, bin_i)
                           : from_reg({1'b0, regs_i.hr[6:0]}, bin_i)
                             + (regs_i.hr[7] ? 7'd12 : 7'd0);
        tod_o.wday = from_reg(regs_i.wday, bin_i);
        tod_o.mday = from_reg(regs_i.mday, bin_i);
        tod_o.mon  = from_reg(regs_i.mon, bin_i);
        tod_o.year = from_reg(regs_i.year, bin_i);
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int UIP_CYCLES = 12207,
    parameter int CENTURY    = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [7:0] mode_i,
    input  logic [2:0] osc_i,
    input  logic [7:0] alm_sec_i,
    input  logic [7:0] alm_min_i,
    input  logic [7:0] alm_hr_i,
    input  logic       ld_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hr_i,
    input  logic [7:0] ld_wday_i,
    input  logic [7:0] ld_mday_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_year_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip_o,
    output logic [7:0] flags_o
);
    localparam int            CW   = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

    upd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    tod_t          tod_q, tod_step, tod_ld;
    regs_t         regs_q, regs_enc, ld_bytes;
    logic          uip_q;
    logic [7:0]    flags_q;

    logic hold, bin, h24, go, alm_hit, alm_fire, uend_fire;
    logic unused_mode;

    assign hold        = mode_i[MB_HOLD];
    assign bin         = mode_i[MB_BIN];
    assign h24         = mode_i[MB_H24];
    assign unused_mode = ^{mode_i[6], mode_i[3], mode_i[0]};
    assign go          = tick_i && !ld_i && (osc_i == OSC_RUN);
    assign ld_bytes    = '{ld_sec_i, ld_min_i, ld_hr_i, ld_wday_i,
                           ld_mday_i, ld_mon_i, ld_year_i};

    rtc_cal_step #(.CENTURY(CENTURY)) u_step (.cur_i(tod_q), .nxt_o(tod_step));
    rtc_cal_encode u_enc (.tod_i(tod_q), .bin_i(bin), .h24_i(h24), .regs_o(regs_enc));
    rtc_cal_decode u_dec (.regs_i(ld_bytes), .bin_i(bin), .h24_i(h24), .tod_o(tod_ld));

    function automatic logic field_hit(input logic [7:0] alm, input logic [7:0] cur);
        return (alm[7:6] == 2'b11) || (alm == cur);
    endfunction

    assign alm_hit   = field_hit(alm_sec_i, regs_enc.sec) &&
                       field_hit(alm_min_i, regs_enc.min) &&
                       field_hit(alm_hr_i,  regs_enc.hr);
    assign alm_fire  = alm_hit && mode_i[MB_ALM_EN];
    assign uend_fire = mode_i[MB_UEND_EN] && !hold;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go) state_d = S_BUSY;
            S_BUSY:  if (cnt_q == LAST) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tod_q   <= TOD_RESET;
            regs_q  <= REGS_RESET;
            cnt_q   <= '0;
            uip_q   <= 1'b0;
            flags_q <= 8'h00;
        end else begin
            flags_q <= 8'h00;
            if (state_q == S_IDLE && go) begin
                tod_q <= tod_step;
                uip_q <= !hold;
                cnt_q <= '0;
            end
            if (state_q == S_BUSY) cnt_q <= cnt_q + 1'b1;
            if (hold) uip_q <= 1'b0;
            if (state_q == S_DONE) begin
                uip_q <= 1'b0;
                if (!hold) regs_q <= regs_enc;
                flags_q[FB_ANY]  <= alm_fire || uend_fire;
                flags_q[FB_ALM]  <= alm_fire;
                flags_q[FB_UEND] <= uend_fire;
            end
            if (ld_i) begin
                tod_q  <= tod_ld;
                regs_q <= ld_bytes;
            end
        end
    end

    assign sec_o   = regs_q.sec;
    assign min_o   = regs_q.min;
    assign hr_o    = regs_q.hr;
    assign wday_o  = regs_q.wday;
    assign mday_o  = regs_q.mday;
    assign mon_o   = regs_q.mon;
    assign year_o  = regs_q.year;
    assign uip_o   = uip_q;
    assign flags_o = flags_q;

    // R2
    osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && osc_i != OSC_RUN && !ld_i) |=> $stable(tod_q));

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !ld_i) |=> $stable({sec_o, min_o, hr_o, wday_o, mday_o, mon_o, year_o}));

    // R10
    flag_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o != 8'h00) |-> $past(state_q == S_DONE));

    // R10
    idle_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !uip_o);

    // R10
    uip_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip_o) |-> (state_q == S_BUSY));

endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
    localparam int NWIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] mode = 8'h02;
    logic [2:0] osc = 3'b010;
    logic [7:0] a_s = 8'h00, a_m = 8'h00, a_h = 8'h00;
    logic       ld = 1'b0;
    logic [7:0] l_s = 0, l_m = 0, l_h = 0, l_wd = 0, l_md = 0, l_mo = 0, l_y = 0;
    logic [7:0] sec, min, hr, wday, mday, mon, year, flags;
    logic       uip;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #10ns clk = ~clk;

    rtc_calendar_core #(.UIP_CYCLES(NWIN), .CENTURY(20)) u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .osc_i(osc),
        .alm_sec_i(a_s), .alm_min_i(a_m), .alm_hr_i(a_h),
        .ld_i(ld), .ld_sec_i(l_s), .ld_min_i(l_m), .ld_hr_i(l_h),
        .ld_wday_i(l_wd), .ld_mday_i(l_md), .ld_mon_i(l_mo), .ld_year_i(l_y),
        .sec_o(sec), .min_o(min), .hr_o(hr), .wday_o(wday), .mday_o(mday),
        .mon_o(mon), .year_o(year), .uip_o(uip), .flags_o(flags));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic load(input logic [7:0] s, m, h, wd, md, mo, y);
        @(negedge clk);
        ld = 1'b1; l_s = s; l_m = m; l_h = h; l_wd = wd; l_md = md; l_mo = mo; l_y = y;
        @(negedge clk);
        ld = 1'b0;
    endtask

    // Returns at the cycle where registers refresh and flags pulse
    task automatic tick_once(output logic uip_seen);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; uip_seen = uip;
        repeat (NWIN + 1) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sec", sec, 8'h00);   chk("R1 min", min, 8'h00);
        chk("R1 hr", hr, 8'h00);     chk("R1 wday", wday, 8'h01);
        chk("R1 mday", mday, 8'h01); chk("R1 mon", mon, 8'h01);
        chk("R1 year", year, 8'h00); chk("R1 uip", {7'b0, uip}, 8'h00);
        chk("R1 flags", flags, 8'h00);
    endtask

    task automatic t_rollover();
        logic u;
        mode = 8'h02;
        load(8'h59, 8'h14, 8'h08, 8'h03, 8'h15, 8'h06, 8'h22);
        chk("R12 loaded sec", sec, 8'h59);
        chk("R12 loaded min", min, 8'h14);
        tick_once(u);
        chk("R10 uip raised", {7'b0, u}, 8'h01);
        chk("R10 uip cleared", {7'b0, uip}, 8'h00);
        chk("R3 sec carry", sec, 8'h00);
        chk("R3 min carry", min, 8'h15);
        chk("R3 hr kept", hr, 8'h08);
        @(negedge clk);
        chk("R10 flags one cycle", flags, 8'h00);
        load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick_once(u);
        chk("R3 hr wrap", hr, 8'h00);
        chk("R3 wday wrap", wday, 8'h01);
        chk("R4 dec to jan mday", mday, 8'h01);
        chk("R4 dec to jan mon", mon, 8'h01);
        chk("R5 year wrap", year, 8'h00);
    endtask

    task automatic day_end(input string tag, input logic [7:0] md, mo, y,
                           input logic [7:0] emd, emo);
        logic u;
        load(8'h59, 8'h59, 8'h23, 8'h02, md, mo, y);
        tick_once(u);
        chk({tag, " mday"}, mday, emd);
        chk({tag, " mon"}, mon, emo);
    endtask

    task automatic t_months();
        mode = 8'h02;
        day_end("R4 feb28 y00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
        day_end("R4 feb29 y00", 8'h29, 8'h02, 8'h00, 8'h01, 8'h03);
        day_end("R4 feb28 y01", 8'h28, 8'h02, 8'h01, 8'h01, 8'h03);
        day_end("R4 feb28 y04", 8'h28, 8'h02, 8'h04, 8'h29, 8'h02);
        day_end("R4 apr30", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
        day_end("R4 jan30", 8'h30, 8'h01, 8'h21, 8'h31, 8'h01);
        chk("R3 wday step", wday, 8'h03);
    endtask

    task automatic t_binary();
        logic u;
        mode = 8'h02;
        load(8'h09, 8'h00, 8'h05, 8'h01, 8'h01, 8'h01, 8'h10);
        tick_once(u);
        chk("R6 bcd sec 9->10", sec, 8'h10);
        mode = 8'h06;
        load(8'd9, 8'd0, 8'd5, 8'd1, 8'd1, 8'd1, 8'd10);
        tick_once(u);
        chk("R6 bin sec 9->10", sec, 8'h0A);
        load(8'd59, 8'd59, 8'd23, 8'd1, 8'd28, 8'd2, 8'd24);
        tick_once(u);
        chk("R6 bin mday", mday, 8'd29);
        chk("R6 bin year", year, 8'd24);
        chk("R6 bin hr", hr, 8'd0);
    endtask

    task automatic t_twelve();
        logic u;
        mode = 8'h00;
        load(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h05, 8'h20);
        tick_once(u);
        chk("R7 noon", hr, 8'h80);
        load(8'h59, 8'h59, 8'h81, 8'h01, 8'h10, 8'h05, 8'h20);
        tick_once(u);
        chk("R7 1pm to 2pm", hr, 8'h82);
        load(8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h05, 8'h20);
        tick_once(u);
        chk("R7 11pm to midnight", hr, 8'h00);
        chk("R7 midnight day", mday, 8'h11);
        mode = 8'h04;
        load(8'd59, 8'd59, 8'h89, 8'd1, 8'd10, 8'd5, 8'd20);
        tick_once(u);
        chk("R7 bin 9pm to 10pm", hr, 8'h8A);
    endtask

    task automatic t_osc();
        logic u;
        mode = 8'h02;
        load(8'h10, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h00);
        osc = 3'b000;
        tick_once(u);
        chk("R2 no uip osc000", {7'b0, u}, 8'h00);
        osc = 3'b110;
        tick_once(u);
        osc = 3'b010;
        tick_once(u);
        chk("R2 only one step", sec, 8'h11);
    endtask

    task automatic t_alarm();
        logic u;
        mode = 8'h22;
        load(8'h29, 8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        a_s = 8'h30; a_m = 8'hC0; a_h = 8'h10;
        tick_once(u);
        chk("R8 match with dc min", flags, 8'hA0);
        @(negedge clk);
        chk("R10 flag pulse ends", flags, 8'h00);
        a_s = 8'h31; a_m = 8'h21;
        tick_once(u);
        chk("R8 min mismatch", flags, 8'h00);
        a_s = 8'hFF; a_m = 8'hC5; a_h = 8'hD0;
        tick_once(u);
        chk("R8 all dc", flags, 8'hA0);
        mode = 8'h02;
        tick_once(u);
        chk("R8 enable off", flags, 8'h00);
        mode = 8'h20;
        load(8'h59, 8'h59, 8'h81, 8'h01, 8'h01, 8'h01, 8'h00);
        a_s = 8'h00; a_m = 8'h00; a_h = 8'h82;
        tick_once(u);
        chk("R8 12h format compare", flags, 8'hA0);
    endtask

    task automatic t_uend();
        logic u;
        a_s = 8'h01; a_m = 8'h01; a_h = 8'h01;
        mode = 8'h12;
        tick_once(u);
        chk("R9 update ended", flags, 8'h90);
        mode = 8'h32;
        a_s = 8'hC0; a_m = 8'hC0; a_h = 8'hC0;
        tick_once(u);
        chk("R9 with alarm", flags, 8'hB0);
    endtask

    task automatic t_hold();
        logic u;
        mode = 8'h92;
        load(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00);
        tick_once(u);
        chk("R11 no uip", {7'b0, u}, 8'h00);
        chk("R11 frozen sec", sec, 8'h00);
        chk("R11 no uend flag", flags, 8'h00);
        tick_once(u);
        mode = 8'h12;
        tick_once(u);
        chk("R11 caught up", sec, 8'h03);
        chk("R11 uend resumes", flags, 8'h90);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rollover();
        t_months();
        t_binary();
        t_twelve();
        t_osc();
        t_alarm();
        t_uend();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule